// File: doc/BRIEF.md
# DRAM Access Timing Generator

This block sequences one access to an asynchronous DRAM. It drives the row strobe and the column strobe, both active low, and it drives a shared address bus that carries either the row half or the column half of the address. All delays are whole clock cycles. The block has two ways of working, and the host picks one with a mode input while the block is idle.

In automatic mode, the host pulls one active-low access strobe. The block then asserts the row strobe and holds the row address for a fixed number of cycles. It then switches the bus to the column address and, a fixed number of cycles later, asserts the column strobe. The row/column select and the column request inputs play no part in this sequence, so they are passed out on a refresh port for a refresh controller.

In externally controlled mode, the host steers the bus with the row/column select and asks for the column strobe with a request input. The column strobe is held off while the bus carries the row. If the request is already raised when the bus switches to the column, the strobe follows at once. Page or nibble accesses are made by toggling the request. Row and column addresses pass through internal latches, so the host may remove them once they are captured. When the strobe is released, the block enforces a precharge gap before it starts the next access.

Top module: `dram_access_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, rasN and casN are 1 and muxAddr is 0, because both address latches reset to zero.
- R2: In externally controlled mode, casN is never 0 while muxAddr carries the row latch, even when casReq is 1.
- R3: In externally controlled mode, an edge that samples colSel=1 with casReq already 1 puts the column latch on muxAddr and sets casN=0 in the same following cycle. No new request edge is needed.
- R4: During an externally controlled access, each edge after the start edge samples colSel (1 = column) and casReq (1 = request). In the following cycle muxAddr shows the column latch if colSel was 1 and the row latch otherwise, and casN is 0 exactly when both were 1. Toggling casReq therefore makes page accesses, with a fresh column address latched between toggles.
- R5: In the first cycle after the row strobe asserts, muxAddr carries the row latch and casN is 1, whatever colSel and casReq are.
- R6: In automatic mode, the edge that samples accessN=0 sets rasN=0. The column latch appears on muxAddr after ROW_HOLD further edges, and casN goes to 0 after ROW_HOLD+CAS_DELAY further edges. colSel and casReq have no effect on this sequence.
- R7: While automatic mode is in force, rfshSel and rfshReq follow colSel and casReq. While externally controlled mode is in force, both are 0.
- R8: An edge that samples accessN=1 during an access sets rasN=1 and casN=1 and returns muxAddr to the row latch in the following cycle.
- R9: After rasN returns to 1, it stays 1 for at least PRECHARGE cycles. If accessN is held low through the precharge, rasN falls again exactly PRECHARGE edges after the release edge.
- R10: autoMode is sampled only at an edge where a new access could start. A change made during an access does not alter that access.
- R11: An edge with latchEn=1 captures rowAddr and colAddr. While latchEn is 0, changes on rowAddr and colAddr do not reach muxAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accessN | input | 1 | Access strobe, active low |
| colSel | input | 1 | Row/column select, 1 = column (externally controlled mode) |
| casReq | input | 1 | Column strobe request, 1 = request (externally controlled mode) |
| autoMode | input | 1 | 1 = automatic mode, 0 = externally controlled mode |
| latchEn | input | 1 | 1 = capture the address inputs at the edge |
| rowAddr | input | AW | Row address |
| colAddr | input | AW | Column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| muxAddr | output | AW | Multiplexed DRAM address |
| rfshSel | output | 1 | colSel passed to the refresh port in automatic mode |
| rfshReq | output | 1 | casReq passed to the refresh port in automatic mode |

## Verification
Two pairs of events can land on the same edge. First, releasing the strobe can coincide with the edge on which the automatic sequence would switch the column or assert its column strobe. Second, the strobe can already be low on the edge where precharge ends. The bench provokes both by sweeping the strobe-low length from one to seven cycles and re-asserting the strobe right after each release. Every expected level comes from the cycle count since the start edge and the configured delays: release must win over the pending column strobe, and the new row strobe must appear on the exact precharge-expiry edge.

// File: rtl/dram_timer_pkg.sv
package dram_timer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PRE    = 2'd2
  } timerState_t;

  typedef struct packed {
    logic rasOn;
    logic colOn;
    logic casOn;
    logic rfshEn;
  } strobe_t;

endpackage

// File: rtl/dram_timer_ctrl.sv
module dram_timer_ctrl
  import dram_timer_pkg::*;
#(
  parameter int ROW_HOLD  = 2,
  parameter int CAS_DELAY = 2,
  parameter int PRECHARGE = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    accessN,
  input  logic    colSel,
  input  logic    casReq,
  input  logic    autoMode,
  output strobe_t strobes
);

  localparam int CAS_AT  = ROW_HOLD + CAS_DELAY;
  localparam int CNT_MAX = (CAS_AT > PRECHARGE) ? CAS_AT : PRECHARGE;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(ROW_HOLD);
  localparam logic [CW-1:0] CASAT_C = CW'(CAS_AT);
  localparam logic [CW-1:0] PRELAST_C = CW'(PRECHARGE - 1);
  localparam logic [CW-1:0] PREFULL_C = CW'(PRECHARGE);

  timerState_t state;
  logic [CW-1:0] cnt;
  logic modeReg;
  logic curAuto;
  logic colReg;
  logic casReg;

  logic preDone;
  logic canStart;
  logic startNow;

  assign preDone  = (state == ST_PRE) && (cnt == PRELAST_C);
  assign canStart = (state == ST_IDLE) || preDone;
  assign startNow = canStart && !accessN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      modeReg <= 1'b0;
      curAuto <= 1'b0;
      colReg  <= 1'b0;
      casReg  <= 1'b0;
    end else begin
      if (canStart) curAuto <= autoMode;
      if (startNow) begin
        state   <= ST_ACTIVE;
        cnt     <= '0;
        modeReg <= autoMode;
        colReg  <= 1'b0;
        casReg  <= 1'b0;
      end else if (preDone) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (state == ST_PRE) begin
        cnt <= cnt + 1'b1;
      end else if (state == ST_ACTIVE) begin
        if (accessN) begin
          state  <= ST_PRE;
          cnt    <= '0;
          colReg <= 1'b0;
          casReg <= 1'b0;
        end else begin
          if (cnt < CASAT_C) cnt <= cnt + 1'b1;
          colReg <= colSel;
          casReg <= casReq;
        end
      end
    end
  end

  always_comb begin
    strobes.rasOn  = (state == ST_ACTIVE);
    strobes.rfshEn = curAuto;
    if (state != ST_ACTIVE) begin
      strobes.colOn = 1'b0;
      strobes.casOn = 1'b0;
    end else if (modeReg) begin
      strobes.colOn = (cnt >= HOLD_C);
      strobes.casOn = (cnt >= CASAT_C);
    end else begin
      strobes.colOn = colReg;
      strobes.casOn = colReg && casReg;
    end
  end

  // Cycles the row strobe has been off, saturating at the precharge count.
  logic [CW-1:0] rasOffCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rasOffCnt <= PREFULL_C;
    else if (strobes.rasOn) rasOffCnt <= '0;
    else if (rasOffCnt < PREFULL_C) rasOffCnt <= rasOffCnt + 1'b1;
  end

  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && accessN) |=> (!strobes.rasOn && !strobes.colOn && !strobes.casOn));

  a_r6_cas_after_col: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg && $rose(strobes.casOn)) |-> $past(strobes.colOn));

  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && $past(state) == ST_ACTIVE) |-> $stable(modeReg));

  a_r9_precharge_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.rasOn) |-> (rasOffCnt >= PREFULL_C));

  a_r5_first_cycle_row: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.rasOn) |-> (!strobes.colOn && !strobes.casOn));

endmodule

// File: rtl/dram_timer_path.sv
module dram_timer_path
  import dram_timer_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          latchEn,
  input  logic [AW-1:0] rowAddr,
  input  logic [AW-1:0] colAddr,
  input  logic          colSel,
  input  logic          casReq,
  input  strobe_t       strobes,
  output logic          rasN,
  output logic          casN,
  output logic [AW-1:0] muxAddr,
  output logic          rfshSel,
  output logic          rfshReq
);

  logic [AW-1:0] rowLat;
  logic [AW-1:0] colLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowLat <= '0;
      colLat <= '0;
    end else if (latchEn) begin
      rowLat <= rowAddr;
      colLat <= colAddr;
    end
  end

  assign rasN    = !strobes.rasOn;
  assign casN    = !strobes.casOn;
  assign muxAddr = strobes.colOn ? colLat : rowLat;
  assign rfshSel = strobes.rfshEn && colSel;
  assign rfshReq = strobes.rfshEn && casReq;

  a_r2_cas_needs_col: assert property (@(posedge clk) disable iff (!rstN)
    strobes.casOn |-> (strobes.colOn && strobes.rasOn));

  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(latchEn) |-> ($stable(rowLat) && $stable(colLat)));

endmodule

// File: rtl/dram_access_timer.sv
module dram_access_timer
  import dram_timer_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ROW_HOLD  = 2,
  parameter int CAS_DELAY = 2,
  parameter int PRECHARGE = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accessN,
  input  logic          colSel,
  input  logic          casReq,
  input  logic          autoMode,
  input  logic          latchEn,
  input  logic [AW-1:0] rowAddr,
  input  logic [AW-1:0] colAddr,
  output logic          rasN,
  output logic          casN,
  output logic [AW-1:0] muxAddr,
  output logic          rfshSel,
  output logic          rfshReq
);

  strobe_t strobes;

  dram_timer_ctrl #(
    .ROW_HOLD (ROW_HOLD),
    .CAS_DELAY(CAS_DELAY),
    .PRECHARGE(PRECHARGE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accessN (accessN),
    .colSel  (colSel),
    .casReq  (casReq),
    .autoMode(autoMode),
    .strobes (strobes)
  );

  dram_timer_path #(
    .AW(AW)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .latchEn(latchEn),
    .rowAddr(rowAddr),
    .colAddr(colAddr),
    .colSel (colSel),
    .casReq (casReq),
    .strobes(strobes),
    .rasN   (rasN),
    .casN   (casN),
    .muxAddr(muxAddr),
    .rfshSel(rfshSel),
    .rfshReq(rfshReq)
  );

endmodule

// File: tb/dram_access_timer_bench.sv
module dram_access_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int RH  = 2;
  localparam int CD  = 2;
  localparam int PRE = 3;

  logic clk = 1'b0;
  logic rstN, accessN, colSel, casReq, autoMode, latchEn;
  logic [AW-1:0] rowAddr, colAddr;
  logic rasN, casN, rfshSel, rfshReq;
  logic [AW-1:0] muxAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dram_access_timer #(.AW(AW), .ROW_HOLD(RH), .CAS_DELAY(CD), .PRECHARGE(PRE)) u_dram_access_timer (
    .clk(clk), .rstN(rstN), .accessN(accessN), .colSel(colSel), .casReq(casReq),
    .autoMode(autoMode), .latchEn(latchEn), .rowAddr(rowAddr), .colAddr(colAddr),
    .rasN(rasN), .casN(casN), .muxAddr(muxAddr), .rfshSel(rfshSel), .rfshReq(rfshReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] prevV;
    logic [AW-1:0] expMux;
    rstN = 0; accessN = 1; colSel = 0; casReq = 0; autoMode = 1; latchEn = 0;
    rowAddr = 8'hFF; colAddr = 8'hEE;
    tick(); tick();
    check("R1 reset rasN", rasN, 1);
    check("R1 reset casN", casN, 1);
    check("R1 reset muxAddr", muxAddr, 0);
    rstN = 1;
    tick();
    check("R1 after reset rasN", rasN, 1);
    check("R1 after reset muxAddr", muxAddr, 0);

    // Capture addresses, then close the latches (R11).
    latchEn = 1; rowAddr = 8'h12; colAddr = 8'h34;
    tick();
    latchEn = 0;

    // Automatic mode sweep over strobe-low lengths.
    for (int len = 1; len <= 7; len++) begin
      autoMode = 1; accessN = 1;
      repeat (PRE + 1) tick();
      rowAddr = 8'hA0 ^ 8'(len); colAddr = 8'hC0 ^ 8'(len);
      accessN = 0;
      for (int k = 0; k < len; k++) begin
        colSel = 1'((k / 2) % 2);
        casReq = 1'(k % 2);
        autoMode = (k == 0) ? 1'b1 : 1'b0;  // R10: change after start is ignored
        tick();
        check("R6 auto rasN", rasN, 0);
        check("R6 auto casN", casN, (k >= RH + CD) ? 0 : 1);
        check("R11 R6 auto muxAddr", muxAddr, (k >= RH) ? 8'h34 : 8'h12);
        check("R7 auto rfshSel", rfshSel, colSel);
        check("R7 auto rfshReq", rfshReq, casReq);
      end
      autoMode = 1; accessN = 1;
      tick();
      check("R8 release rasN", rasN, 1);
      check("R8 release casN", casN, 1);
      check("R8 release muxAddr", muxAddr, 8'h12);
      accessN = 0;
      for (int j = 1; j <= PRE; j++) begin
        tick();
        check("R9 precharge rasN", rasN, (j < PRE) ? 1 : 0);
      end
      accessN = 1;
      tick();
    end

    // Externally controlled mode.
    autoMode = 0; accessN = 1; colSel = 0; casReq = 0;
    repeat (PRE + 1) tick();
    colSel = 1; casReq = 1;
    tick();
    check("R7 ext rfshSel", rfshSel, 0);
    check("R7 ext rfshReq", rfshReq, 0);
    latchEn = 1; rowAddr = 8'h5A; colAddr = 8'hA5; accessN = 0;
    tick();
    check("R5 first cycle rasN", rasN, 0);
    check("R5 first cycle muxAddr", muxAddr, 8'h5A);
    check("R5 first cycle casN", casN, 1);
    prevV = 2'b00;
    for (int step = 0; step < 32; step++) begin
      logic [1:0] v;
      v = (step % 2 == 0) ? 2'((step / 2) / 4) : 2'((step / 2) % 4);
      colSel = v[1]; casReq = v[0];
      colAddr = 8'h80 + 8'(step);
      autoMode = 1'(step % 2);  // R10: ignored during this access
      tick();
      expMux = v[1] ? (8'h80 + 8'(step)) : 8'h5A;
      check("R4 ext muxAddr", muxAddr, expMux);
      check("R4 R2 ext casN", casN, (v[1] && v[0]) ? 0 : 1);
      check("R10 R7 ext rfshSel", rfshSel, 0);
      if (!prevV[1] && v == 2'b11)
        check("R3 auto column strobe", casN, 0);
      prevV = v;
    end
    autoMode = 0; accessN = 1;
    tick();
    check("R8 ext release rasN", rasN, 1);
    check("R8 ext release casN", casN, 1);
    check("R8 ext release muxAddr", muxAddr, 8'h5A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule